// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block sits in the execute stage of a 32-bit load-store processor. It takes one instruction word, the program counter (already advanced past that instruction), and the values of two register-file read ports. It decodes the memory-class opcodes and works out the byte address they touch. A memory access leaves the block as an address with a read or write strobe. An address-only operation leaves it as a register write-back.

Two address forms exist. The displacement form adds a sign-extended 17-bit constant to a base register. A base field of zero selects absolute addressing with the constant alone, so register 0 is never used as a base. The relative form adds a sign-extended 22-bit constant to the program counter. Memory is byte addressed and big-endian. The block turns the four byte lanes returned by memory into a word whose lowest-addressed byte is the most significant. Every write-back, whether it carries load data or an address, is registered and appears one cycle after the instruction was presented.

Top module: `lsea_unit`

## Requirements
- R1: Field positions are fixed. The opcode is bits 31..27, the target/source register index is bits 26..22, and the base register index is bits 21..17. The short constant is bits 16..0 and the long constant is bits 21..0. `base_sel_o` shows the base index and `src_sel_o` shows the target index. Word 0D880018h therefore selects base 4 and target 22 with opcode 1.
- R2: If the base index is 0, the displacement address is the sign-extended short constant alone. Constant 0FFFFh gives 0000FFFFh, 10000h gives FFFF0000h and 1FFFFh gives FFFFFFFFh.
- R3: If the base index is not 0, the displacement address is the base value plus the sign-extended short constant, modulo 2^32.
- R4: The relative address is `pc_i` plus the sign-extended long constant, modulo 2^32.
- R5: Opcode 1 raises `mem_rd_o` only, with `mem_addr_o` set to the displacement address. One cycle later it writes the assembled word to the target index.
- R6: Opcode 2 behaves like opcode 1 but uses the relative address.
- R7: Opcode 3 raises `mem_wr_o` only, with the displacement address and `mem_wdata_o` set to `src_val_i`. No write-back follows it.
- R8: Opcode 4 behaves like opcode 3 but uses the relative address.
- R9: Opcode 5 raises no strobe. One cycle later it writes the displacement address to the target index.
- R10: Opcode 6 raises no strobe. One cycle later it writes the relative address to the target index.
- R11: Byte lane k of `mem_rdata_i` (bits 8k+7..8k) holds the byte at address+k. The loaded word puts lane 0 in bits 31..24, lane 1 in 23..16, lane 2 in 15..8 and lane 3 in 7..0.
- R12: Every other opcode raises no strobe and causes no write-back one cycle later.
- R13: While `rst_n` is low, `wb_en_o`, `wb_idx_o` and `wb_val_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Program counter already advanced by 4 |
| base_sel_o | output | 5 | Register index for the base read port |
| base_val_i | input | 32 | Value of register `base_sel_o` |
| src_sel_o | output | 5 | Register index for the store-data read port |
| src_val_i | input | 32 | Value of register `src_sel_o` |
| mem_addr_o | output | 32 | Effective byte address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 32 | Store data, zero when not writing |
| mem_rdata_i | input | 32 | Four byte lanes read at `mem_addr_o` |
| wb_en_o | output | 1 | Registered write-back enable |
| wb_idx_o | output | 5 | Registered write-back register index |
| wb_val_o | output | 32 | Registered write-back value |

## Verification
The properties assume that memory answers a read in the same cycle as the strobe. They also assume both register read ports return the value of the index they are shown combinationally, so the write-back one cycle later reflects a single presented instruction. The stimulus changes every input only at the falling edge and models the register file and the byte-addressed memory as pure functions of the selects and the address, which keeps those assumptions true. The address-related properties compare the registered write-back with the instruction and read values of the previous cycle. Reset holds until after several edges, so no `$past` reaches back before reset.

// File: rtl/lsea_pkg.sv
package lsea_pkg;
    localparam int DW     = 32;
    localparam int RW     = 5;
    localparam int OPW    = 5;
    localparam int SHORTW = 17;
    localparam int LONGW  = 22;
    localparam int BYTEW  = 8;

    localparam logic [OPW-1:0] OP_LD_DISP = 5'd1;
    localparam logic [OPW-1:0] OP_LD_REL  = 5'd2;
    localparam logic [OPW-1:0] OP_ST_DISP = 5'd3;
    localparam logic [OPW-1:0] OP_ST_REL  = 5'd4;
    localparam logic [OPW-1:0] OP_LA_DISP = 5'd5;
    localparam logic [OPW-1:0] OP_LA_REL  = 5'd6;

    typedef struct packed {
        logic use_rel;
        logic rd;
        logic wr;
        logic wb;
        logic wb_load;
    } ctl_t;

    typedef struct packed {
        logic          en;
        logic [RW-1:0] idx;
        logic [DW-1:0] val;
    } wb_t;
endpackage

// File: rtl/lsea_decode.sv
module lsea_decode
    import lsea_pkg::*;
(
    input  logic [DW-1:0]     instr,
    output logic [OPW-1:0]    op,
    output logic [RW-1:0]     ra,
    output logic [RW-1:0]     rb,
    output logic [SHORTW-1:0] c_short,
    output logic [LONGW-1:0]  c_long,
    output ctl_t              ctl
);
    localparam int OP_LSB = DW - OPW;
    localparam int RA_LSB = OP_LSB - RW;
    localparam int RB_LSB = RA_LSB - RW;

    assign op      = instr[DW-1 -: OPW];
    assign ra      = instr[RA_LSB +: RW];
    assign rb      = instr[RB_LSB +: RW];
    assign c_short = instr[SHORTW-1:0];
    assign c_long  = instr[LONGW-1:0];

    always_comb begin
        ctl = '0;
        case (op)
            OP_LD_DISP: begin ctl.rd = 1'b1; ctl.wb = 1'b1; ctl.wb_load = 1'b1; end
            OP_LD_REL:  begin ctl.rd = 1'b1; ctl.wb = 1'b1; ctl.wb_load = 1'b1; ctl.use_rel = 1'b1; end
            OP_ST_DISP: begin ctl.wr = 1'b1; end
            OP_ST_REL:  begin ctl.wr = 1'b1; ctl.use_rel = 1'b1; end
            OP_LA_DISP: begin ctl.wb = 1'b1; end
            OP_LA_REL:  begin ctl.wb = 1'b1; ctl.use_rel = 1'b1; end
            default:    ctl = '0;
        endcase
    end
endmodule

// File: rtl/lsea_agen.sv
module lsea_agen #(
    parameter int DW     = 32,
    parameter int RW     = 5,
    parameter int SHORTW = 17,
    parameter int LONGW  = 22
) (
    input  logic [RW-1:0]     rb,
    input  logic [DW-1:0]     base_val,
    input  logic [SHORTW-1:0] c_short,
    input  logic [LONGW-1:0]  c_long,
    input  logic [DW-1:0]     pc,
    input  logic              use_rel,
    output logic [DW-1:0]     addr
);
    localparam int SPAD = DW - SHORTW;
    localparam int LPAD = DW - LONGW;

    logic [DW-1:0] short_x, long_x, disp, rel;

    assign short_x = {{SPAD{c_short[SHORTW-1]}}, c_short};
    assign long_x  = {{LPAD{c_long[LONGW-1]}}, c_long};
    // absolute mode when the base field is zero: register 0 never joins the sum
    assign disp    = (rb == '0) ? short_x : base_val + short_x;
    assign rel     = pc + long_x;
    assign addr    = use_rel ? rel : disp;
endmodule

// File: rtl/lsea_bytes.sv
module lsea_bytes #(
    parameter int DW    = 32,
    parameter int BYTEW = 8
) (
    input  logic [DW-1:0] lanes,
    output logic [DW-1:0] word
);
    localparam int NB = DW / BYTEW;

    // lane k holds address+k; the lowest address lands in the top byte
    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign word[DW-1-k*BYTEW -: BYTEW] = lanes[k*BYTEW +: BYTEW];
    end
endmodule

// File: rtl/lsea_unit.sv
module lsea_unit
    import lsea_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   instr_i,
    input  logic [31:0]   pc_i,
    output logic [4:0]    base_sel_o,
    input  logic [31:0]   base_val_i,
    output logic [4:0]    src_sel_o,
    input  logic [31:0]   src_val_i,
    output logic [31:0]   mem_addr_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i,
    output logic          wb_en_o,
    output logic [4:0]    wb_idx_o,
    output logic [31:0]   wb_val_o
);
    logic [OPW-1:0]    op;
    logic [RW-1:0]     ra, rb;
    logic [SHORTW-1:0] c_short;
    logic [LONGW-1:0]  c_long;
    ctl_t              ctl;
    logic [DW-1:0]     addr, load_word;
    wb_t               wb_d, wb_q;

    lsea_decode i_decode (
        .instr   (instr_i),
        .op      (op),
        .ra      (ra),
        .rb      (rb),
        .c_short (c_short),
        .c_long  (c_long),
        .ctl     (ctl)
    );

    lsea_agen #(.DW(DW), .RW(RW), .SHORTW(SHORTW), .LONGW(LONGW)) i_agen (
        .rb       (rb),
        .base_val (base_val_i),
        .c_short  (c_short),
        .c_long   (c_long),
        .pc       (pc_i),
        .use_rel  (ctl.use_rel),
        .addr     (addr)
    );

    lsea_bytes #(.DW(DW), .BYTEW(BYTEW)) i_bytes (
        .lanes (mem_rdata_i),
        .word  (load_word)
    );

    assign base_sel_o  = rb;
    assign src_sel_o   = ra;
    assign mem_addr_o  = addr;
    assign mem_rd_o    = ctl.rd;
    assign mem_wr_o    = ctl.wr;
    assign mem_wdata_o = ctl.wr ? src_val_i : '0;

    always_comb begin
        wb_d = '0;
        if (ctl.wb) begin
            wb_d.en  = 1'b1;
            wb_d.idx = ra;
            wb_d.val = ctl.wb_load ? load_word : addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    assign wb_en_o  = wb_q.en;
    assign wb_idx_o = wb_q.idx;
    assign wb_val_o = wb_q.val;

    logic unused_op;
    assign unused_op = ^op;
endmodule

// File: rtl/lsea_chk.sv
module lsea_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_i,
    input logic [31:0] pc_i,
    input logic [31:0] base_val_i,
    input logic [31:0] mem_rdata_i,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic        wb_en_o,
    input logic [4:0]  wb_idx_o,
    input logic [31:0] wb_val_o
);
    logic [4:0]  op_w, rb_w;
    logic [31:0] sx_short, sx_long;
    assign op_w     = instr_i[31:27];
    assign rb_w     = instr_i[21:17];
    assign sx_short = {{15{instr_i[16]}}, instr_i[16:0]};
    assign sx_long  = {{10{instr_i[21]}}, instr_i[21:0]};

    // R13
    always_comb if (!rst_n) rst_clear_chk: assert (!wb_en_o && wb_val_o == '0);

    // R5
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    // R5
    read_then_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> wb_en_o);

    // R7
    store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> !wb_en_o);

    // R9
    addr_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == 5'd5 || op_w == 5'd6) |-> (!mem_rd_o && !mem_wr_o));

    // R12
    other_op_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == 5'd0 || op_w > 5'd6) |=> !wb_en_o);

    // R2
    abs_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == 5'd5 && rb_w == 5'd0) |=> (wb_val_o == $past(sx_short)));

    // R3
    based_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == 5'd5 && rb_w != 5'd0) |=> (wb_val_o == $past(base_val_i + sx_short)));

    // R10
    rel_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == 5'd6) |=> (wb_en_o && wb_idx_o == $past(instr_i[26:22])
                            && wb_val_o == $past(pc_i + sx_long)));

    // R11
    load_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> (wb_val_o[31:24] == $past(mem_rdata_i[7:0])));
endmodule

bind lsea_unit lsea_chk i_lsea_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_i     (instr_i),
    .pc_i        (pc_i),
    .base_val_i  (base_val_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .wb_en_o     (wb_en_o),
    .wb_idx_o    (wb_idx_o),
    .wb_val_o    (wb_val_o)
);

// File: tb/test_lsea_unit.sv
module test_lsea_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0, pc_i = '0;
    logic [4:0]  base_sel_o, src_sel_o, wb_idx_o;
    logic [31:0] base_val_i, src_val_i, mem_addr_o, mem_wdata_o, mem_rdata_i, wb_val_o;
    logic        mem_rd_o, mem_wr_o, wb_en_o;

    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lsea_unit i_lsea_unit (.*);

    function automatic logic [31:0] rf(input logic [4:0] i);
        if (i == 5'd0)  return 32'hDEAD_0000;
        if (i == 5'd31) return 32'hFFFF_FFF0;
        return 32'h0101_0101 * i + 32'h100;
    endfunction

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[3:0]} ^ a[31:24] ^ 8'h3C;
    endfunction

    assign base_val_i = rf(base_sel_o);
    assign src_val_i  = rf(src_sel_o);
    always_comb
        for (int k = 0; k < 4; k++) mem_rdata_i[k*8 +: 8] = mbyte(mem_addr_o + k);

    typedef struct { bit en; logic [4:0] idx; logic [31:0] val; string tag; } exp_t;
    exp_t q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [31:0] pcv, input string tag);
        logic [4:0] op, ra, rb;
        logic [31:0] disp, rel, addr, ld;
        bit rd, wr, wb, isl;
        exp_t e;
        op = ins[31:27]; ra = ins[26:22]; rb = ins[21:17];
        disp = (rb == 0) ? {{15{ins[16]}}, ins[16:0]} : rf(rb) + {{15{ins[16]}}, ins[16:0]};
        rel  = pcv + {{10{ins[21]}}, ins[21:0]};
        addr = (op == 2 || op == 4 || op == 6) ? rel : disp;
        rd = (op == 1 || op == 2); wr = (op == 3 || op == 4);
        wb = rd || op == 5 || op == 6; isl = rd;
        ld = {mbyte(addr), mbyte(addr + 1), mbyte(addr + 2), mbyte(addr + 3)};
        @(negedge clk);
        instr_i = ins; pc_i = pcv;
        #1;
        chk(base_sel_o == rb && src_sel_o == ra, {tag, " R1 selects"}, {base_sel_o, src_sel_o}, {rb, ra});
        chk(mem_rd_o == rd, {tag, " rd strobe"}, mem_rd_o, rd);
        chk(mem_wr_o == wr, {tag, " wr strobe"}, mem_wr_o, wr);
        if (rd || wr) chk(mem_addr_o == addr, {tag, " address"}, mem_addr_o, addr);
        if (wr) chk(mem_wdata_o == rf(ra), {tag, " store data"}, mem_wdata_o, rf(ra));
        e.en = wb; e.idx = ra; e.val = isl ? ld : addr;
        e.tag = isl ? {tag, " R11 word"} : tag;
        q.push_back(e);
    endtask

    always begin
        exp_t e;
        @(posedge clk); #5;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk(wb_en_o == e.en, {e.tag, " wb enable"}, wb_en_o, e.en);
            if (e.en) begin
                chk(wb_idx_o == e.idx, {e.tag, " wb index"}, wb_idx_o, e.idx);
                chk(wb_val_o == e.val, {e.tag, " wb value"}, wb_val_o, e.val);
            end
        end
    end

    function automatic logic [31:0] f1(input int op, ra, rb, input logic [16:0] c);
        return {op[4:0], ra[4:0], rb[4:0], c};
    endfunction
    function automatic logic [31:0] f2(input int op, ra, input logic [21:0] c);
        return {op[4:0], ra[4:0], c};
    endfunction

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #5;
        chk(!wb_en_o && wb_idx_o == 0 && wb_val_o == 0, "R13 reset", wb_val_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run(32'h0D88_0018,              32'h0000_0100, "R1 R3 R5 encoding");
        run(f1(1, 7, 0, 17'h0FFFF),     32'h0,         "R2 R5 top positive");
        run(f1(1, 8, 0, 17'h10000),     32'h0,         "R2 R5 most negative");
        run(f1(5, 9, 0, 17'h1FFFF),     32'h0,         "R2 R9 minus one");
        run(f1(1, 3, 31, 17'h00020),    32'h0,         "R3 R5 wrap");
        run(f2(2, 4, 22'h3FFFF8),       32'h0000_2000, "R4 R6 back");
        run(f2(2, 5, 22'h1FFFFF),       32'hFFF0_0000, "R4 R6 forward");
        run(f1(3, 6, 3, 17'h00010),     32'h0,         "R7 based store");
        run(f1(3, 10, 0, 17'h1FFF0),    32'h0,         "R7 R2 absolute store");
        run(f2(4, 11, 22'h000040),      32'h0000_4000, "R8 rel store");
        run(f1(5, 12, 5, 17'h1FFFC),    32'h0,         "R9 R3 based address");
        run(f2(6, 13, 22'h200000),      32'h0040_0000, "R10 R4 rel address");
        run(f1(1, 14, 2, 17'h00003),    32'h0,         "R5 R11 unaligned");
        run(f1(0, 15, 2, 17'h00003),    32'h0,         "R12 op0");
        run(f1(7, 16, 2, 17'h00003),    32'h0,         "R12 op7");
        run(f1(12, 17, 2, 17'h00003),   32'h0,         "R12 op12");
        run(f1(31, 18, 0, 17'h0),       32'h0,         "R12 op31");
        run(f2(6, 19, 22'h0),           32'h8000_0004, "R10 zero offset");
        run(f1(0, 0, 0, 17'h0),         32'h0,         "R12 idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule